// File: doc/BRIEF.md
# Intensity Histogram Peak-Count Sorter

This block decides whether one inspected object on a sorting line is kept or ejected. It works from the shape of the object's brightness distribution, not from a single pixel threshold. Pixels arrive as 8-bit intensities framed by an object-start pulse and an object-end pulse. Each valid pixel increments one bin of a 256-bin histogram. When the object closes, a scanner walks the histogram one bin per clock. It counts local maxima ("peaks") that reach a programmable height, and it counts how many bins hold at least a programmable significance level (the "spread"). It then emits a one-cycle verdict together with both counts. The verdict can drive an ejector request directly.

The object is kept only when exactly one peak exists and the spread stays within a programmable width. Several peaks, no peak at all, or a broad distribution all lead to rejection. Two histogram banks alternate, so the next object can start streaming while the previous one is being scanned. The scanner clears each bin as it reads it.

One scan occupies 258 cycles. At 125 MHz that is about 2 µs per decision, far below the 1 ms budget and well above 50,000 decisions per second. One pixel is accepted every clock, which covers a 20.5 Mpixel/s line-scan feed. If an object starts while one finished histogram is still waiting for the scanner, no bank is free. That object is discarded and a sticky overrun flag is raised.

Top module: `intensity_peak_sorter`

## Requirements
- R1: Every cycle with `pix_valid`=1, from the cycle carrying `obj_start` through the cycle carrying `obj_end` inclusive, adds one to the histogram bin whose index equals `pix_data`. Pixels outside an object are not counted.
- R2: A bin counts as a peak when all three of these hold: its count is at least `min_height`; its count is strictly greater than the bin one index lower; its count is greater than or equal to the bin one index higher.
- R3: Bin 0 and bin 255 treat their missing neighbour as a count of zero. A run of equal counts forms a plateau, and a plateau contributes exactly one peak.
- R4: `spread_count` equals the number of bins whose count is at least `sig_level`. An object whose `spread_count` exceeds `max_width` is rejected.
- R5: `reject`=0 (keep) only when `peak_count`=1 and `spread_count` ≤ `max_width`. An object with zero peaks, including an object with no pixels, is rejected.
- R6: `decision_valid` is high for exactly one cycle per object. When the scanner is idle, it rises on the 257th rising edge after the edge that samples `obj_end`.
- R7: A new object may start in the cycle right after the previous `obj_end`. Decisions come out in object order, and no count leaks from one object into a later one.
- R8: An object that starts while a finished histogram is still waiting for the scanner is discarded. It produces no decision, and `overrun` goes to 1 and stays at 1 until reset.
- R9: Bin counts saturate at 65535 and do not wrap.
- R10: After reset, `decision_valid`=0, `reject`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 8 | Pixel intensity, used as the bin index |
| obj_start | input | 1 | First cycle of an object |
| obj_end | input | 1 | Last cycle of an object |
| min_height | input | 16 | Minimum count for a bin to be a peak |
| sig_level | input | 16 | Count at which a bin adds to the spread |
| max_width | input | 9 | Largest spread that is still kept |
| decision_valid | output | 1 | One-cycle verdict strobe |
| reject | output | 1 | 1 = eject the object |
| peak_count | output | 9 | Peaks found in the object |
| spread_count | output | 9 | Bins at or above `sig_level` |
| overrun | output | 1 | Sticky: an object was discarded |

## Verification
The assertions assume three things about the inputs:
- Objects are well framed: each `obj_start` is followed by exactly one `obj_end` before the next `obj_start`, and the two may fall in the same cycle for an empty object.
- `pix_valid` is only asserted inside an object.
- The three thresholds stay constant while a scan runs.

The bench keeps to these assumptions in three ways. Each object's pixels are sent from a bin-count table by a single driver task that sets both markers itself. Thresholds change only after every outstanding verdict has been drained. The overrun case is produced by chaining objects back to back through the same task, not by breaking the framing.

// File: rtl/intensity_peak_sorter.sv
module intensity_peak_sorter #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16,
  localparam int NBINS = 1 << PIX_W,
  localparam int IW = PIX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             obj_start,
  input  logic             obj_end,
  input  logic [CNT_W-1:0] min_height,
  input  logic [CNT_W-1:0] sig_level,
  input  logic [IW-1:0]    max_width,
  output logic             decision_valid,
  output logic             reject,
  output logic [IW-1:0]    peak_count,
  output logic [IW-1:0]    spread_count,
  output logic             overrun
);

  logic [CNT_W-1:0] hist [2][NBINS];
  logic             fill_bank, scan_bank, scan_busy, pending;
  logic             collecting, dropping;
  logic [IW-1:0]    idx, pk, sp;
  logic [CNT_W-1:0] c_prev, c_cur;

  wire in_obj   = collecting | obj_start;
  wire drop_now = obj_start ? pending : dropping;
  wire take_pix = pix_valid & in_obj & ~drop_now;
  wire handoff  = obj_end & in_obj & ~drop_now;

  wire             last = (idx == IW'(NBINS));
  wire [CNT_W-1:0] rd   = last ? '0 : hist[scan_bank][idx[PIX_W-1:0]];
  wire is_peak = (idx != '0) && (c_cur >= min_height) && (c_cur > c_prev) && (c_cur >= rd);
  wire is_sig  = !last && (rd >= sig_level);
  wire [IW-1:0] pk_nx = pk + IW'(is_peak);
  wire [IW-1:0] sp_nx = sp + IW'(is_sig);

  wire [CNT_W-1:0] cur_cnt = hist[fill_bank][pix_data];
  wire [CNT_W-1:0] inc_cnt = (&cur_cnt) ? cur_cnt : cur_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NBINS; i++)
          hist[b][i] <= '0;
    end else begin
      if (scan_busy && !last)
        hist[scan_bank][idx[PIX_W-1:0]] <= '0;
      if (take_pix)
        hist[fill_bank][pix_data] <= inc_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_bank      <= 1'b0;
      scan_bank      <= 1'b0;
      scan_busy      <= 1'b0;
      pending        <= 1'b0;
      collecting     <= 1'b0;
      dropping       <= 1'b0;
      idx            <= '0;
      pk             <= '0;
      sp             <= '0;
      c_prev         <= '0;
      c_cur          <= '0;
      decision_valid <= 1'b0;
      reject         <= 1'b0;
      peak_count     <= '0;
      spread_count   <= '0;
      overrun        <= 1'b0;
    end else begin
      decision_valid <= 1'b0;
      collecting     <= in_obj & ~obj_end;
      dropping       <= (in_obj & ~obj_end) ? drop_now : 1'b0;
      if (obj_start && pending)
        overrun <= 1'b1;

      if (scan_busy) begin
        c_prev <= c_cur;
        c_cur  <= rd;
        pk     <= pk_nx;
        sp     <= sp_nx;
        idx    <= idx + IW'(1);
        if (last) begin
          scan_busy      <= 1'b0;
          decision_valid <= 1'b1;
          peak_count     <= pk_nx;
          spread_count   <= sp_nx;
          reject         <= (pk_nx != IW'(1)) || (sp_nx > max_width);
        end
      end else if (pending || handoff) begin
        scan_busy <= 1'b1;
        scan_bank <= fill_bank;
        fill_bank <= ~fill_bank;
        pending   <= 1'b0;
        idx       <= '0;
        pk        <= '0;
        sp        <= '0;
        c_prev    <= '0;
        c_cur     <= '0;
      end

      if (handoff && scan_busy)
        pending <= 1'b1;
    end
  end

  // R6
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |=> !decision_valid);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !take_pix);

  // R7
  bank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> (scan_bank != fill_bank));

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && !reject) |-> (peak_count == IW'(1)));

  // R4
  spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && (spread_count > max_width)) |-> reject);

endmodule

// File: tb/intensity_peak_sorter_test.sv
module intensity_peak_sorter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        obj_start = 1'b0;
  logic        obj_end = 1'b0;
  logic [15:0] min_height = 16'd5;
  logic [15:0] sig_level = 16'd5;
  logic [8:0]  max_width = 9'd8;
  logic        decision_valid, reject, overrun;
  logic [8:0]  peak_count, spread_count;

  int tests = 0, fails = 0;
  int cyc = 0, end_cyc = 0, dec_cyc = 0;
  int hist_m [256];
  logic [18:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  intensity_peak_sorter uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .obj_start(obj_start), .obj_end(obj_end), .min_height(min_height),
    .sig_level(sig_level), .max_width(max_width), .decision_valid(decision_valid),
    .reject(reject), .peak_count(peak_count), .spread_count(spread_count),
    .overrun(overrun));

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 256; i++) hist_m[i] = 0;
  endtask

  function automatic logic [18:0] model();
    int c [256];
    int pk = 0, sp = 0;
    for (int i = 0; i < 256; i++) c[i] = (hist_m[i] > 65535) ? 65535 : hist_m[i];
    for (int i = 0; i < 256; i++) begin
      int l = (i > 0) ? c[i-1] : 0;
      int r = (i < 255) ? c[i+1] : 0;
      if (c[i] >= int'(min_height) && c[i] > l && c[i] >= r) pk++;
      if (c[i] >= int'(sig_level)) sp++;
    end
    return {(pk != 1) || (sp > int'(max_width)), 9'(pk), 9'(sp)};
  endfunction

  task automatic send_obj(input bit expect_drop, input string tag);
    int n = 0, j = 0;
    if (!expect_drop) begin
      exp_q.push_back(model());
      tag_q.push_back(tag);
    end
    for (int b = 0; b < 256; b++) n += hist_m[b];
    if (n == 0) begin
      @(negedge clk);
      pix_valid = 1'b0; obj_start = 1'b1; obj_end = 1'b1; end_cyc = cyc;
    end else begin
      for (int b = 0; b < 256; b++)
        for (int k = 0; k < hist_m[b]; k++) begin
          @(negedge clk);
          pix_valid = 1'b1; pix_data = 8'(b);
          obj_start = (j == 0); obj_end = (j == n - 1);
          if (j == n - 1) end_cyc = cyc;
          j++;
        end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    pix_valid = 1'b0; obj_start = 1'b0; obj_end = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (decision_valid) begin
      logic [18:0] got;
      got = {reject, peak_count, spread_count};
      dec_cyc = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7/R8 unexpected decision", $sformatf("%h", got), "none");
      end else begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t,
            $sformatf("rej=%0d pk=%0d sp=%0d", got[18], got[17:9], got[8:0]),
            $sformatf("rej=%0d pk=%0d sp=%0d", e[18], e[17:9], e[8:0]));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(decision_valid == 1'b0 && reject == 1'b0, "R10 outputs after reset",
        $sformatf("%0d%0d", decision_valid, reject), "00");
    chk(overrun == 1'b0, "R10 overrun after reset", $sformatf("%0d", overrun), "0");

    // R1 R5 single narrow peak, R6 latency
    clr(); hist_m[100] = 10; hist_m[101] = 20; hist_m[102] = 10;
    send_obj(0, "R1 R5 single peak kept"); idle(); drain();
    chk(dec_cyc - end_cyc == 258, "R6 decision latency",
        $sformatf("%0d", dec_cyc - end_cyc), "258");

    // R2 two separate peaks
    clr(); hist_m[50] = 30; hist_m[200] = 30;
    send_obj(0, "R2 two peaks rejected"); idle(); drain();

    // R3 plateau
    clr(); hist_m[80] = 15; hist_m[81] = 15;
    send_obj(0, "R3 plateau one peak"); idle(); drain();

    // R3 edge bins
    clr(); hist_m[0] = 20; hist_m[255] = 20;
    send_obj(0, "R3 edge bins"); idle(); drain();

    // R4 broad ramp
    clr(); for (int i = 0; i < 20; i++) hist_m[60+i] = 6 + i;
    send_obj(0, "R4 broad spread rejected"); idle(); drain();

    // R5 empty object
    clr();
    send_obj(0, "R5 empty object rejected"); idle(); drain();

    // R2 bump below min_height
    clr(); hist_m[100] = 30; hist_m[150] = 3;
    send_obj(0, "R2 low bump ignored"); idle(); drain();

    // R4 raised width limit keeps the ramp
    max_width = 9'd20;
    clr(); for (int i = 0; i < 20; i++) hist_m[60+i] = 6 + i;
    send_obj(0, "R4 spread at limit kept"); idle(); drain();
    max_width = 9'd8;

    chk(overrun == 1'b0, "R8 no overrun yet", $sformatf("%0d", overrun), "0");

    // R7 R8 back-to-back, pending bank, dropped third object
    clr(); hist_m[40] = 20; hist_m[41] = 20;
    send_obj(0, "R7 first of chain");
    clr(); hist_m[10] = 30; hist_m[90] = 30;
    send_obj(0, "R7 second of chain");
    clr(); hist_m[120] = 10;
    send_obj(1, "R8 dropped");
    idle(); drain();
    chk(overrun == 1'b1, "R8 overrun raised", $sformatf("%0d", overrun), "1");

    // R7 no leakage after chain
    clr(); hist_m[200] = 12;
    send_obj(0, "R7 clean bank after chain"); idle(); drain();
    clr(); hist_m[10] = 7;
    send_obj(0, "R7 clean other bank"); idle(); drain();
    chk(overrun == 1'b1, "R8 overrun sticky", $sformatf("%0d", overrun), "1");

    // R9 saturation
    min_height = 16'd65535; sig_level = 16'd65535; max_width = 9'd1;
    clr(); hist_m[100] = 65536;
    send_obj(0, "R9 saturated bin"); idle(); drain();

    chk(exp_q.size() == 0, "R7 all decisions seen", $sformatf("%0d", exp_q.size()), "0");
    summary();
    $finish;
  end
endmodule